// File: doc/BRIEF.md
# Boot Vector Overlay

The overlay sits next to a page-translating address decoder on a 24-bit, 16-bit-wide, big-endian bus. From reset it answers reads of the lowest eight bytes of the logical space with two fixed longwords. A processor that takes its initial stack pointer and program counter from address zero can therefore start with its stack at the top of the RAM window and its first instruction at the start of the flash window. This works before software has programmed any page mapping.

While it is armed, the overlay blocks the SRAM and flash selects that the page decoder produces for that eight-byte window. Writes into the window are dropped. All other addresses, including the rest of page 0, pass through unchanged. Software disarms the overlay for good by writing the byte 0x00 to the control address. Only a new reset arms it again. A read of the control address reports whether the overlay is still armed.

Top module: `boot_vec_overlay`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the overlay is armed, and `armed` reads 1.
- R2: While armed, a read (req=1, wr=0) of byte address 0x0, 0x2, 0x4 or 0x6 sets `ovl_drive`=1 and returns 0x00E0, 0x0000, 0x00F0 or 0x0000 respectively on `ovl_rdata`. These are the big-endian halves of the longwords 0x00E00000 and 0x00F00000.
- R3: While armed, any access to byte addresses 0x0–0x7 forces `ram_sel` and `flash_sel` to 0, whatever the page decoder asks for.
- R4: While armed, a write into the window drives no select and no data, and leaves the window contents unchanged.
- R5: Outside the window, and outside a read of the control address, `ram_sel`/`flash_sel` equal `mmu_ram_sel`/`mmu_flash_sel` and `ovl_drive` is 0. This holds even while armed and even elsewhere in page 0.
- R6: A write to byte address 0xE10010 with the upper lane strobe `ub`=1 and `wdata_hi`=0x00 disarms the overlay from the next clock cycle.
- R7: A write to 0xE10010 with a non-zero `wdata_hi`, or with `ub`=0, leaves the armed state unchanged.
- R8: Once disarmed, the overlay stays disarmed until the next reset, and window accesses follow the page decoder exactly.
- R9: A read of 0xE10010 sets `ovl_drive`=1 and returns the status byte on the upper lane: 0x0100 while armed, 0x0000 once disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus access valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 23 | Word address (byte address bits 23..1) |
| ub | input | 1 | Upper (even-address) byte lane strobe |
| wdata_hi | input | 8 | Write data on the upper byte lane |
| mmu_ram_sel | input | 1 | SRAM select from the page decoder |
| mmu_flash_sel | input | 1 | Flash select from the page decoder |
| ram_sel | output | 1 | SRAM select after the overlay |
| flash_sel | output | 1 | Flash select after the overlay |
| ovl_drive | output | 1 | Overlay drives the read data bus |
| ovl_rdata | output | 16 | Read data from the overlay |
| armed | output | 1 | Overlay currently armed |

## Verification
The assertions assume that bus inputs only change between clock edges and that `req` qualifies every access, so a cycle with req=0 carries no meaning. They also assume the page decoder's selects are arbitrary inputs, which the overlay only gates. The stimulus drives each access half a period away from the rising edge and returns `req` to 0 between accesses. It sweeps all four combinations of the decoder selects through every window word and several addresses just outside the window, so every gating case is seen in both armed and disarmed states.

// File: rtl/ovl_pkg.sv
// Shared constants for the boot vector overlay.
// Assumes a 16-bit big-endian data bus.
package ovl_pkg;
    localparam int BUS_W  = 16;
    localparam int LANE_W = 8;
endpackage

// File: rtl/ovl_addr_dec.sv
// Address decoder: flags accesses that fall in the low vector window or hit
// the control word. Assumes the address is a word address (byte bit 0 dropped).
module ovl_addr_dec #(
    parameter int          ADDR_W    = 24,
    parameter int          WIN_BYTES = 8,
    parameter logic [23:0] CTRL_ADDR = 24'hE10010
) (
    input  logic [ADDR_W-1:1] addr,
    output logic              win_hit,
    output logic              ctl_hit
);
    localparam int WIN_LSB = $clog2(WIN_BYTES);

    // Compare the high address bits against the window base and control word.
    always_comb begin
        win_hit = (addr[ADDR_W-1:WIN_LSB] == '0);
        ctl_hit = (addr == CTRL_ADDR[ADDR_W-1:1]);
    end
endmodule

// File: rtl/ovl_vec_rom.sv
// Fixed vector image: two big-endian longwords, stack then entry, split
// into 16-bit words. Assumes WIN_BYTES covers exactly the two longwords.
module ovl_vec_rom
    import ovl_pkg::*;
#(
    parameter int          WIN_BYTES = 8,
    parameter logic [31:0] STACK_VEC = 32'h00E00000,
    parameter logic [31:0] ENTRY_VEC = 32'h00F00000
) (
    input  logic [$clog2(WIN_BYTES/2)-1:0] idx,
    output logic [BUS_W-1:0]               word
);
    localparam int WORDS = WIN_BYTES / 2;
    localparam int IMG_W = WORDS * BUS_W;
    localparam logic [IMG_W-1:0] IMAGE = {STACK_VEC, ENTRY_VEC};

    logic [BUS_W-1:0] table_q [WORDS];

    // One constant word per window slot, most significant half first.
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign table_q[i] = IMAGE[IMG_W-1-BUS_W*i -: BUS_W];
    end

    // Select the addressed slot.
    always_comb word = table_q[idx];
endmodule

// File: rtl/ovl_arm_reg.sv
// Arm flag: set by reset, cleared once by the disarm byte write, never set
// again until reset. Assumes wdata is the upper (even) byte lane.
module ovl_arm_reg
    import ovl_pkg::*;
#(
    parameter logic [LANE_W-1:0] DISARM_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [LANE_W-1:0] wdata,
    output logic              armed
);
    // Hold the arm flag; only the exact disarm code clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (wr_ctl && wdata == DISARM_CODE)
            armed <= 1'b0;
    end
endmodule

// File: rtl/boot_vec_overlay.sv
// Boot vector overlay: serves fixed reset vectors at the low window while
// armed, gates the page decoder's memory selects there, and exposes an
// arm/status byte at the control address. Assumes inputs are stable around
// the rising clock edge and req qualifies every access.
module boot_vec_overlay
    import ovl_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter int                WIN_BYTES   = 8,
    parameter logic [23:0]       CTRL_ADDR   = 24'hE10010,
    parameter logic [LANE_W-1:0] DISARM_CODE = 8'h00,
    parameter logic [31:0]       STACK_VEC   = 32'h00E00000,
    parameter logic [31:0]       ENTRY_VEC   = 32'h00F00000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:1] addr,
    input  logic              ub,
    input  logic [LANE_W-1:0] wdata_hi,
    input  logic              mmu_ram_sel,
    input  logic              mmu_flash_sel,
    output logic              ram_sel,
    output logic              flash_sel,
    output logic              ovl_drive,
    output logic [BUS_W-1:0]  ovl_rdata,
    output logic              armed
);
    localparam int IDX_W = $clog2(WIN_BYTES / 2);

    logic             win_hit, ctl_hit;
    logic             take_win, rd_win, rd_ctl, wr_ctl;
    logic [BUS_W-1:0] rom_word;

    ovl_addr_dec #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr(addr), .win_hit(win_hit), .ctl_hit(ctl_hit)
    );

    ovl_vec_rom #(
        .WIN_BYTES(WIN_BYTES), .STACK_VEC(STACK_VEC), .ENTRY_VEC(ENTRY_VEC)
    ) u_rom (
        .idx(addr[IDX_W:1]), .word(rom_word)
    );

    ovl_arm_reg #(
        .DISARM_CODE(DISARM_CODE)
    ) u_arm (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(wdata_hi), .armed(armed)
    );

    // Classify the current access.
    always_comb begin
        take_win = req && armed && win_hit;
        rd_win   = take_win && !wr;
        rd_ctl   = req && ctl_hit && !wr;
        wr_ctl   = req && ctl_hit && wr && ub;
    end

    // Gate memory selects inside the armed window.
    always_comb begin
        ram_sel   = mmu_ram_sel   && !take_win;
        flash_sel = mmu_flash_sel && !take_win;
    end

    // Drive vector words or the status byte onto the read path.
    always_comb begin
        ovl_drive = rd_win || rd_ctl;
        if (rd_win)
            ovl_rdata = rom_word;
        else if (rd_ctl)
            ovl_rdata = {{(LANE_W-1){1'b0}}, armed, {LANE_W{1'b0}}};
        else
            ovl_rdata = '0;
    end
endmodule

// File: rtl/boot_vec_overlay_chk.sv
// Property checker for boot_vec_overlay, attached by bind below.
module boot_vec_overlay_chk #(
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] CTRL_ADDR = 24'hE10010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              wr,
    input logic [ADDR_W-1:1] addr,
    input logic              ub,
    input logic [7:0]        wdata_hi,
    input logic              mmu_ram_sel,
    input logic              mmu_flash_sel,
    input logic              ram_sel,
    input logic              flash_sel,
    input logic              ovl_drive,
    input logic [15:0]       ovl_rdata,
    input logic              armed
);
    logic in_win, at_ctl;
    always_comb begin
        in_win = (addr[ADDR_W-1:3] == '0);
        at_ctl = (addr == CTRL_ADDR[ADDR_W-1:1]);
    end

    assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(armed)) |-> !armed);

    assert_window_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && armed && in_win) |-> (!ram_sel && !flash_sel));

    assert_stack_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && armed && in_win && addr[2:1] == 2'd0) |-> (ovl_drive && ovl_rdata == 16'h00E0));

    assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req && in_win)) |-> (ram_sel == mmu_ram_sel && flash_sel == mmu_flash_sel));

    assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && ub && at_ctl && wdata_hi == 8'h00) |=> !armed);

    assert_keep_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && req && wr && at_ctl && (!ub || wdata_hi != 8'h00)) |=> armed);

    assert_win_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && in_win && armed) |-> !ovl_drive);
endmodule

bind boot_vec_overlay boot_vec_overlay_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .ub(ub),
    .wdata_hi(wdata_hi), .mmu_ram_sel(mmu_ram_sel), .mmu_flash_sel(mmu_flash_sel),
    .ram_sel(ram_sel), .flash_sel(flash_sel), .ovl_drive(ovl_drive),
    .ovl_rdata(ovl_rdata), .armed(armed)
);

// File: tb/boot_vec_overlay_test.sv
module boot_vec_overlay_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0, ub = 1'b0;
    logic [23:1] addr = '0;
    logic [7:0]  wdata_hi = '0;
    logic        mmu_ram_sel = 1'b0, mmu_flash_sel = 1'b0;
    logic        ram_sel, flash_sel, ovl_drive, armed;
    logic [15:0] ovl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    boot_vec_overlay uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .ub(ub),
        .wdata_hi(wdata_hi), .mmu_ram_sel(mmu_ram_sel), .mmu_flash_sel(mmu_flash_sel),
        .ram_sel(ram_sel), .flash_sel(flash_sel), .ovl_drive(ovl_drive),
        .ovl_rdata(ovl_rdata), .armed(armed)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // Present an access at the falling edge; outputs settle combinationally.
    task automatic put(input logic r, input logic w, input logic [23:0] byte_addr,
                       input logic u, input logic [7:0] d, input logic mr, input logic mf);
        @(negedge clk);
        req = r; wr = w; addr = byte_addr[23:1]; ub = u; wdata_hi = d;
        mmu_ram_sel = mr; mmu_flash_sel = mf;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0; wr = 1'b0; ub = 1'b0; mmu_ram_sel = 1'b0; mmu_flash_sel = 1'b0;
    endtask

    function automatic logic [15:0] vec_word(input int idx);
        logic [31:0] v;
        v = (idx < 2) ? 32'h00E00000 : 32'h00F00000;
        return (idx % 2 == 0) ? v[31:16] : v[15:0];
    endfunction

    task automatic ctl_write(input logic u, input logic [7:0] d);
        put(1'b1, 1'b1, 24'hE10010, u, d, 1'b0, 1'b0);
        idle();
    endtask

    task automatic status_read(input string tag, input logic [15:0] exp);
        put(1'b1, 1'b0, 24'hE10010, 1'b1, 8'h00, 1'b0, 1'b0);
        check({tag, " drive"}, {31'b0, ovl_drive}, 32'd1);
        check({tag, " status"}, {16'b0, ovl_rdata}, {16'b0, exp});
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        logic [23:0] outside [7];
        outside = '{24'h000008, 24'h00000A, 24'h00000E, 24'h000010,
                    24'h0FFFFE, 24'h100000, 24'h600000};
        do_reset();
        // R1 / R9: armed after reset, status byte set
        check("R1 armed", {31'b0, armed}, 32'd1);
        status_read("R9 armed", 16'h0100);

        // R2 / R3: every window word with every select combination
        for (int i = 0; i < 4; i++)
            for (int s = 0; s < 4; s++) begin
                put(1'b1, 1'b0, 24'(2*i), 1'b1, 8'h00, s[1], s[0]);
                check("R2 drive", {31'b0, ovl_drive}, 32'd1);
                check("R2 data", {16'b0, ovl_rdata}, {16'b0, vec_word(i)});
                check("R3 sels", {30'b0, ram_sel, flash_sel}, 32'd0);
                idle();
            end

        // R4: window writes produce nothing and change nothing
        for (int i = 0; i < 4; i++)
            for (int s = 0; s < 4; s++) begin
                put(1'b1, 1'b1, 24'(2*i), 1'b1, 8'hA5, s[1], s[0]);
                check("R4 sels", {30'b0, ram_sel, flash_sel}, 32'd0);
                check("R4 drive", {31'b0, ovl_drive}, 32'd0);
                idle();
            end
        for (int i = 0; i < 4; i++) begin
            put(1'b1, 1'b0, 24'(2*i), 1'b1, 8'h00, 1'b0, 1'b0);
            check("R4 contents", {16'b0, ovl_rdata}, {16'b0, vec_word(i)});
            idle();
        end

        // R5: outside window pass-through while armed
        for (int a = 0; a < 7; a++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++) begin
                    put(1'b1, w[0], outside[a], 1'b1, 8'h11, s[1], s[0]);
                    check("R5 sels", {30'b0, ram_sel, flash_sel}, 32'(s));
                    check("R5 drive", {31'b0, ovl_drive}, 32'd0);
                    idle();
                end

        // R7: non-zero byte and lower-lane-only writes keep it armed
        ctl_write(1'b1, 8'h5A);
        check("R7 nonzero", {31'b0, armed}, 32'd1);
        ctl_write(1'b1, 8'h01);
        check("R7 one", {31'b0, armed}, 32'd1);
        ctl_write(1'b0, 8'h00);
        check("R7 no lane", {31'b0, armed}, 32'd1);
        status_read("R7 status", 16'h0100);

        // R6: disarm write
        ctl_write(1'b1, 8'h00);
        check("R6 disarmed", {31'b0, armed}, 32'd0);
        status_read("R9 disarmed", 16'h0000);

        // R8: window now follows the decoder
        for (int i = 0; i < 4; i++)
            for (int s = 0; s < 4; s++) begin
                put(1'b1, 1'b0, 24'(2*i), 1'b1, 8'h00, s[1], s[0]);
                check("R8 sels", {30'b0, ram_sel, flash_sel}, 32'(s));
                check("R8 drive", {31'b0, ovl_drive}, 32'd0);
                idle();
            end
        ctl_write(1'b1, 8'h5A);
        check("R8 stays off", {31'b0, armed}, 32'd0);
        do_reset();
        check("R8 reset rearms", {31'b0, armed}, 32'd1);
        status_read("R9 rearmed", 16'h0100);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired got=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule